// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a single input clock by a programmable integer for the feedback path of an integer-N synthesizer. It has three parts. A dual-modulus prescaler divides either by N+1 or by N, as a modulus-select signal chooses. A program counter with a fixed modulus P counts the prescaler's output cycles. A swallow counter counts the first S of those cycles, and while it runs the prescaler divides by N+1. Once the swallow counter has seen S prescaler cycles, the modulus select switches the prescaler to N. When the program counter completes its P cycles, the whole chain restarts. Each output period therefore spans (N+1)·S + N·(P−S) = N·P + S input cycles.

The swallow value S is sampled from an input port while reset is held and again on the clock edge that ends each output period. Changing it at any other time has no effect until the running period closes. The modulus-select signal is brought out as a registered output so that it can be observed. N, P and the width of S are parameters. The defaults are an 8/9 prescaler (N=8), P=16 and a 4-bit S, which makes every S value from 0 to 15 legal and gives division ratios from 128 to 143.

Top module: `psd_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_out` is 0, and `mod_ctrl` is 0 when `s_value` is nonzero.
- R2: For every legal S (0 to P−1; at defaults 0 to 15), consecutive rising edges of `div_out` are exactly N·P+S clock cycles apart (at defaults 128+S).
- R3: `div_out` is high for exactly one clock cycle in each output period.
- R4: `mod_ctrl` encodes the prescaler modulus: 0 selects divide by N+1 and 1 selects divide by N. In each period it is 0 for exactly (N+1)·S cycles, starting on the period's first cycle, and 1 for the remaining N·(P−S) cycles.
- R5: `mod_ctrl` changes value only on a clock edge where a prescaler cycle ends, and it changes at most once inside a period (0 to 1).
- R6: `s_value` is sampled only on the edge that raises `div_out` (and during reset). A change to `s_value` in the middle of a period leaves that period's length and its `mod_ctrl` pattern unchanged.
- R7: With S=0, `mod_ctrl` stays 1 for the whole period and the period is N·P cycles.
- R8: The first output pulse after reset release comes on clock edge N·P+S, counting the first edge with reset low as edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| s_value | input | S_W | Swallow count S, legal range 0 to P−1 |
| div_out | output | 1 | Divided output, one cycle high per period |
| mod_ctrl | output | 1 | Prescaler modulus select (0: N+1, 1: N) |

## Verification
The hardest case to reach from the ports is a change of `s_value` partway through a period. The old value has to govern the running period and the new one the following period, which is visible only as a period length and a modulus-select pattern. For every S from 0 to 15, the bench sets S just after a pulse, lets the next pulse capture it, and then measures the following period. Partway through that measured period it scrambles `s_value`, and it still expects N·P+S cycles, (N+1)·S cycles with `mod_ctrl` low, and a single transition. The S=0 and S=P−1 ends of the sweep exercise a swallow counter that never runs and one that finishes a single prescaler cycle before the program counter.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Prescaler modulus select: WIDE divides by N+1, NARROW by N.
  typedef enum logic {
    MOD_WIDE   = 1'b0,
    MOD_NARROW = 1'b1
  } mod_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int N_DIV = 8,
  localparam int CW = $clog2(N_DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  mod_e mod_sel,
  output logic pre_tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  // A cycle of the prescaler spans lim+1 input clocks.
  assign lim      = (mod_sel == MOD_NARROW) ? CW'(N_DIV - 1) : CW'(N_DIV);
  assign pre_tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (pre_tick) cnt <= '0;
    else               cnt <= cnt + CW'(1);
  end

  // R2: the phase counter never runs past the wide modulus
  a_r2_pre_bounded: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) <= N_DIV);

endmodule

// File: rtl/psd_mod_counter.sv
module psd_mod_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic [W-1:0] count,
  output logic         at_last
);
  assign at_last = (count == last);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + W'(1);
  end

endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int N_DIV = 8,
  parameter int P_DIV = 16,
  parameter int S_W   = 4,
  localparam int PW   = (P_DIV > 2) ? $clog2(P_DIV) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S_W-1:0] s_value,
  output logic           div_out,
  output logic           mod_ctrl
);
  mod_e           mod_sel;
  logic [S_W-1:0] s_lat;
  logic           pre_tick;
  logic [PW-1:0]  prog_cnt;
  logic           prog_last;
  logic [S_W-1:0] swal_cnt;
  logic           swal_last;
  logic [S_W-1:0] swal_limit;
  logic           period_end;
  logic           swal_inc;
  logic           swal_done;

  psd_prescaler #(.N_DIV(N_DIV)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .mod_sel  (mod_sel),
    .pre_tick (pre_tick)
  );

  assign period_end = pre_tick && prog_last;
  assign swal_inc   = pre_tick && (mod_sel == MOD_WIDE) && !period_end;
  assign swal_limit = s_lat - S_W'(1);
  assign swal_done  = swal_inc && swal_last;

  psd_mod_counter #(.W(PW)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .clr     (period_end),
    .inc     (pre_tick),
    .last    (PW'(P_DIV - 1)),
    .count   (prog_cnt),
    .at_last (prog_last)
  );

  psd_mod_counter #(.W(S_W)) u_swal (
    .clk     (clk),
    .rst     (rst),
    .clr     (period_end),
    .inc     (swal_inc),
    .last    (swal_limit),
    .count   (swal_cnt),
    .at_last (swal_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_lat   <= s_value;
      mod_sel <= (s_value == '0) ? MOD_NARROW : MOD_WIDE;
      div_out <= 1'b0;
    end else begin
      div_out <= period_end;
      if (period_end) begin
        s_lat   <= s_value;
        mod_sel <= (s_value == '0) ? MOD_NARROW : MOD_WIDE;
      end else if (swal_done) begin
        mod_sel <= MOD_NARROW;
      end
    end
  end

  assign mod_ctrl = mod_sel;

  // R5: modulus select moves only where a prescaler cycle ends
  a_r5_mod_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(mod_sel)) |-> $past(pre_tick));

  // R3: the output pulse lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R6: the latched swallow value moves only together with the pulse
  a_r6_capture_at_pulse: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(s_lat)) |-> div_out);

  // R4: the swallow counter never passes the latched value
  a_r4_swallow_bound: assert property (@(posedge clk) disable iff (rst)
    swal_cnt <= s_lat);

  // R2: the program counter stays inside its modulus
  a_r2_prog_bound: assert property (@(posedge clk) disable iff (rst)
    32'(prog_cnt) < P_DIV);

  // R7: dividing by N+1 requires a nonzero swallow value
  a_r7_wide_needs_swallow: assert property (@(posedge clk) disable iff (rst)
    (mod_sel == MOD_WIDE) |-> (s_lat != '0));

endmodule

// File: tb/test_psd_divider.sv
`timescale 1ns/1ps
module test_psd_divider;
  localparam int N_DIV = 8;
  localparam int P_DIV = 16;
  localparam int S_W   = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [S_W-1:0] s_value = '0;
  logic           div_out;
  logic           mod_ctrl;

  int n_checks = 0;
  int n_fail   = 0;

  psd_divider #(.N_DIV(N_DIV), .P_DIV(P_DIV), .S_W(S_W)) i_psd_divider (
    .clk      (clk),
    .rst      (rst),
    .s_value  (s_value),
    .div_out  (div_out),
    .mod_ctrl (mod_ctrl)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Wait until div_out is seen high; returns cycles waited.
  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      step();
      cyc++;
    end while (!div_out && cyc < 4 * N_DIV * P_DIV);
  endtask

  initial begin
    int cyc;
    // R1: reset state
    s_value = 4'd5;
    repeat (3) step();
    check(div_out == 1'b0, "R1", div_out, 0);
    check(mod_ctrl == 1'b0, "R1", mod_ctrl, 0);
    rst = 1'b0;
    step();
    check(div_out == 1'b0, "R1", div_out, 0);
    check(mod_ctrl == 1'b0, "R1", mod_ctrl, 0);
    // R8: first pulse after reset release
    cyc = 1;
    while (!div_out && cyc < 4 * N_DIV * P_DIV) begin
      step();
      cyc++;
    end
    check(cyc == N_DIV * P_DIV + 5, "R8", cyc, N_DIV * P_DIV + 5);

    for (int s = 0; s < P_DIV; s++) begin
      int n, low, trans, width_bad, exp_p, exp_low;
      logic prev;
      s_value = S_W'(s);
      wait_pulse(cyc);            // this pulse captures s
      exp_p   = N_DIV * P_DIV + s;
      exp_low = (N_DIV + 1) * s;
      check(mod_ctrl == (s == 0), (s == 0) ? "R7" : "R4", mod_ctrl, int'(s == 0));
      low = (mod_ctrl == 1'b0) ? 1 : 0;
      prev = mod_ctrl;
      trans = 0;
      width_bad = 0;
      n = 0;
      forever begin
        step();
        n++;
        if (n == 1 && div_out) width_bad = 1;
        if (n == 40) s_value = S_W'((s + 7) % P_DIV);  // R6: mid-period change
        if (div_out || n >= 4 * N_DIV * P_DIV) break;
        if (mod_ctrl == 1'b0) low++;
        if (mod_ctrl != prev) trans++;
        prev = mod_ctrl;
      end
      check(n == exp_p, "R2", n, exp_p);
      check(n == exp_p, "R6", n, exp_p);
      check(width_bad == 0, "R3", width_bad, 0);
      check(low == exp_low, "R4", low, exp_low);
      check(trans == ((s == 0) ? 0 : 1), "R5", trans, (s == 0) ? 0 : 1);
      if (s == 0) check(low == 0, "R7", low, 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(1_500_000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule